// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Core

This block is a watchdog timer whose timeout is split into two chained stages. Once enabled, it counts down a first interval taken from a programmable preload. If software does not kick it in time, it raises a one-cycle warning strobe and starts a second interval from a second preload. If the second interval also runs out, the block issues a one-cycle reset request and latches a sticky flag that records a watchdog-caused reboot. Software can read that flag after the restart.

Each preload is scaled by a left shift before it is loaded. A fine setting shifts by 5 and a coarse setting shifts by 15. The counter then decrements once per clock. The warning can be routed to one of two strobes, or it can be suppressed. In free-running mode the first stage starts again by itself after the second stage expires. The block takes its configuration as plain inputs, so bus decoding and register locking sit outside it.

Top module: `dual_stage_wdog`

## Requirements
- R1: After rst_n is released, all four outputs are low and the timer stays idle, with no strobe, until wd_enable rises.
- R2: A stage lasts a fixed number of clock edges. That count is the stage's preload shifted left by 5 when fast_tick=1, or by 15 when fast_tick=0. A product of zero counts as one edge. The clock edge that samples the rise of wd_enable (or a kick) is edge 0, and the expiry strobe appears as a registered output after edge N1.
- R3: When stage 1 expires, a one-cycle strobe appears. It goes on warn_irq when warn_sel=0 and on warn_smi when warn_sel=2. warn_sel values 1 and 3 give no strobe. Stage 2 then starts from stage2_preload, so its expiry falls N2 edges later.
- R4: When stage 2 expires with reboot_en=1, reset_req pulses for one cycle and reboot_cause goes high on the same edge. With reboot_en=0, neither output changes.
- R5: After stage 2 expires, the timer halts when free_run=0. When free_run=1, stage 1 restarts on the same edge, so the next warning falls N1 edges later.
- R6: A kick while wd_enable=1 restarts stage 1 from stage1_preload. This holds in stage 1, in stage 2, and after a halt.
- R7: Driving wd_enable low stops the countdown at once. Kicks are ignored while it is low. The next rise of wd_enable starts a fresh stage 1.
- R8: A kick on the same edge as an expiry wins over it. That expiry produces no strobe, and stage 1 restarts.
- R9: reboot_cause stays high through later operation and through the reset requests the block issues. Only cause_clr=1 or rst_n clears it.
- R10: warn_irq, warn_smi and reset_req are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the counter decrements once per rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wd_enable | input | 1 | Watchdog enable; a rise starts stage 1, and low stops the timer |
| kick | input | 1 | Keep-alive; restarts stage 1 while enabled |
| fast_tick | input | 1 | Prescale select: 1 shifts preloads by 5, 0 shifts them by 15 |
| warn_sel | input | 2 | Warning routing: 0 selects warn_irq, 2 selects warn_smi, 1 and 3 give none |
| reboot_en | input | 1 | Allows a reset request at stage-2 expiry |
| free_run | input | 1 | Restarts stage 1 after stage-2 expiry |
| stage1_preload | input | PRELOAD_W | Preload for stage 1 |
| stage2_preload | input | PRELOAD_W | Preload for stage 2 |
| cause_clr | input | 1 | Clears the sticky reboot-cause flag |
| warn_irq | output | 1 | One-cycle warning strobe, interrupt route |
| warn_smi | output | 1 | One-cycle warning strobe, management route |
| reset_req | output | 1 | One-cycle system reset request |
| reboot_cause | output | 1 | Sticky flag: the watchdog caused a reboot |

## Verification
The keep-alive kick and a stage expiry can land on the same clock edge. The bench provokes this by placing a one-cycle kick exactly on the edge where stage 1 would expire, and again on the edge where stage 2 would expire. In both cases it expects no warning or reset strobe on that edge, and it expects a fresh stage-1 warning N1 edges later. Kicks one edge before and one edge after the expiry are also swept. This confirms that the collision is resolved on exactly one edge and does not shift the schedule by one.

// File: rtl/wdog2_pkg.sv
package wdog2_pkg;

  // Countdown phase held by the controller
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ONE  = 2'd1,
    ST_TWO  = 2'd2
  } wd_stage_e;

  // Warning routing codes seen on warn_sel
  localparam logic [1:0] WARN_CODE_IRQ = 2'd0;
  localparam logic [1:0] WARN_CODE_SMI = 2'd2;

endpackage

// File: rtl/wdog2_loadsel.sv
module wdog2_loadsel #(
  parameter int PRELOAD_W  = 20,
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5,
  parameter int CNT_W      = PRELOAD_W + SLOW_SHIFT
) (
  input  logic                 use_two,
  input  logic                 fast_tick,
  input  logic [PRELOAD_W-1:0] preload_one,
  input  logic [PRELOAD_W-1:0] preload_two,
  output logic [CNT_W-1:0]     load_val
);

  logic [PRELOAD_W-1:0] picked;
  logic [CNT_W-1:0]     widened;
  logic [CNT_W-1:0]     scaled;

  assign picked  = use_two ? preload_two : preload_one;
  assign widened = CNT_W'(picked);

  generate
    if (FAST_SHIFT == SLOW_SHIFT) begin : g_one_scale
      assign scaled = widened << SLOW_SHIFT;
    end else begin : g_two_scale
      logic [CNT_W-1:0] coarse;
      logic [CNT_W-1:0] fine;
      assign coarse = widened << SLOW_SHIFT;
      assign fine   = widened << FAST_SHIFT;
      assign scaled = fast_tick ? fine : coarse;
    end
  endgenerate

  // A zero interval is stretched to the shortest legal stage of one edge
  always_comb begin
    if (scaled == '0) load_val = CNT_W'(1);
    else              load_val = scaled;
  end

endmodule

// File: rtl/wdog2_counter.sv
module wdog2_counter #(
  parameter int CNT_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = load | (run & (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load)        cnt_d = load_val;
    else if (cnt_en) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = run & (cnt_q <= CNT_W'(1));

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  // R2
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R7
  frozen_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog2_ctrl.sv
module wdog2_ctrl
  import wdog2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wd_enable,
  input  logic       kick,
  input  logic [1:0] warn_sel,
  input  logic       reboot_en,
  input  logic       free_run,
  input  logic       cause_clr,
  input  logic       expire,
  output logic       load,
  output logic       use_two,
  output logic       run,
  output logic       warn_irq,
  output logic       warn_smi,
  output logic       reset_req,
  output logic       reboot_cause
);

  wd_stage_e stage_q, stage_d;
  logic      en_q;
  logic      irq_q, irq_d;
  logic      smi_q, smi_d;
  logic      rst_q, rst_d;
  logic      cause_q, cause_d;
  logic      rise;

  assign rise = wd_enable & ~en_q;
  assign run  = (stage_q != ST_IDLE);

  always_comb begin
    stage_d = stage_q;
    load    = 1'b0;
    use_two = 1'b0;
    irq_d   = 1'b0;
    smi_d   = 1'b0;
    rst_d   = 1'b0;
    cause_d = cause_q;
    if (cause_clr) cause_d = 1'b0;

    if (!wd_enable) begin
      stage_d = ST_IDLE;
    end else if (kick || rise) begin
      stage_d = ST_ONE;
      load    = 1'b1;
    end else if (expire) begin
      case (stage_q)
        ST_ONE: begin
          stage_d = ST_TWO;
          load    = 1'b1;
          use_two = 1'b1;
          irq_d   = (warn_sel == WARN_CODE_IRQ);
          smi_d   = (warn_sel == WARN_CODE_SMI);
        end
        ST_TWO: begin
          if (reboot_en) begin
            rst_d   = 1'b1;
            cause_d = 1'b1;
          end
          if (free_run) begin
            stage_d = ST_ONE;
            load    = 1'b1;
          end else begin
            stage_d = ST_IDLE;
          end
        end
        default: stage_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_IDLE;
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
      smi_q   <= 1'b0;
      rst_q   <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      stage_q <= stage_d;
      en_q    <= wd_enable;
      irq_q   <= irq_d;
      smi_q   <= smi_d;
      rst_q   <= rst_d;
      cause_q <= cause_d;
    end
  end

  assign warn_irq     = irq_q;
  assign warn_smi     = smi_q;
  assign reset_req    = rst_q;
  assign reboot_cause = cause_q;

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({warn_irq, warn_smi, reset_req}));

  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn_irq |=> !warn_irq);

  // R4
  cause_with_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> reboot_cause);

  // R7
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_enable |=> (stage_q == ST_IDLE));

  // R8
  kick_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_enable && kick) |=> (!warn_irq && !warn_smi && !reset_req && stage_q == ST_ONE));

  // R9
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reboot_cause && !cause_clr) |=> reboot_cause);

endmodule

// File: rtl/dual_stage_wdog.sv
module dual_stage_wdog #(
  parameter int PRELOAD_W  = 20,
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wd_enable,
  input  logic                 kick,
  input  logic                 fast_tick,
  input  logic [1:0]           warn_sel,
  input  logic                 reboot_en,
  input  logic                 free_run,
  input  logic [PRELOAD_W-1:0] stage1_preload,
  input  logic [PRELOAD_W-1:0] stage2_preload,
  input  logic                 cause_clr,
  output logic                 warn_irq,
  output logic                 warn_smi,
  output logic                 reset_req,
  output logic                 reboot_cause
);

  localparam int CNT_W = PRELOAD_W + SLOW_SHIFT;

  logic             load;
  logic             use_two;
  logic             run;
  logic             expire;
  logic [CNT_W-1:0] load_val;

  wdog2_loadsel #(
    .PRELOAD_W (PRELOAD_W),
    .SLOW_SHIFT(SLOW_SHIFT),
    .FAST_SHIFT(FAST_SHIFT),
    .CNT_W     (CNT_W)
  ) u_loadsel (
    .use_two    (use_two),
    .fast_tick  (fast_tick),
    .preload_one(stage1_preload),
    .preload_two(stage2_preload),
    .load_val   (load_val)
  );

  wdog2_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .load_val(load_val),
    .run     (run),
    .expire  (expire)
  );

  wdog2_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wd_enable   (wd_enable),
    .kick        (kick),
    .warn_sel    (warn_sel),
    .reboot_en   (reboot_en),
    .free_run    (free_run),
    .cause_clr   (cause_clr),
    .expire      (expire),
    .load        (load),
    .use_two     (use_two),
    .run         (run),
    .warn_irq    (warn_irq),
    .warn_smi    (warn_smi),
    .reset_req   (reset_req),
    .reboot_cause(reboot_cause)
  );

endmodule

// File: tb/dual_stage_wdog_bench.sv
module dual_stage_wdog_bench;

  logic        clk;
  logic        rst_n;
  logic        wd_enable;
  logic        kick;
  logic        fast_tick;
  logic [1:0]  warn_sel;
  logic        reboot_en;
  logic        free_run;
  logic [19:0] stage1_preload;
  logic [19:0] stage2_preload;
  logic        cause_clr;
  logic        warn_irq;
  logic        warn_smi;
  logic        reset_req;
  logic        reboot_cause;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dual_stage_wdog u_dual_stage_wdog (
    .clk(clk), .rst_n(rst_n), .wd_enable(wd_enable), .kick(kick),
    .fast_tick(fast_tick), .warn_sel(warn_sel), .reboot_en(reboot_en),
    .free_run(free_run), .stage1_preload(stage1_preload),
    .stage2_preload(stage2_preload), .cause_clr(cause_clr),
    .warn_irq(warn_irq), .warn_smi(warn_smi), .reset_req(reset_req),
    .reboot_cause(reboot_cause)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_quiet(input string req, input string what);
    check(!warn_irq && !warn_smi && !reset_req, req, what,
          {warn_irq, warn_smi, reset_req}, 0);
  endtask

  function automatic int stage_len(input int p, input bit fast);
    int n;
    n = fast ? (p << 5) : (p << 15);
    return (n == 0) ? 1 : n;
  endfunction

  // One scenario: enable rises so that the next edge is edge 0; an optional
  // one-cycle kick is sampled on edge kick_at (0 means none).
  task automatic run_case(input int p1, input int p2, input bit fast,
                          input int wsel, input bit reb, input bit fr,
                          input int kick_at, input string req);
    int n1;
    int n2;
    int last;
    bit cause_exp;
    n1 = stage_len(p1, fast);
    n2 = stage_len(p2, fast);
    wd_enable      = 1'b0;
    kick           = 1'b0;
    fast_tick      = fast;
    warn_sel       = wsel[1:0];
    reboot_en      = reb;
    free_run       = fr;
    stage1_preload = p1[19:0];
    stage2_preload = p2[19:0];
    cause_clr      = 1'b1;
    step();
    cause_clr = 1'b0;
    step();
    check(reboot_cause == 1'b0, "R9", "cause after clear", reboot_cause, 0);
    wd_enable = 1'b1;
    last = kick_at + n1 + n2 + (fr ? n1 : 0) + 3;
    cause_exp = 1'b0;
    for (int e = 0; e <= last; e++) begin
      bit ew;
      bit er;
      step();
      if (kick_at == 0) begin
        ew = (e == n1) || (fr && e == 2 * n1 + n2);
        er = reb && (e == n1 + n2);
      end else begin
        ew = (e == n1 && n1 < kick_at) || (e == kick_at + n1);
        er = reb && ((e == n1 + n2 && n1 + n2 < kick_at) ||
                     (e == kick_at + n1 + n2));
      end
      if (er) cause_exp = 1'b1;
      check(warn_irq == (ew && wsel == 0), req, $sformatf("warn_irq edge %0d", e),
            warn_irq, (ew && wsel == 0));
      check(warn_smi == (ew && wsel == 2), req, $sformatf("warn_smi edge %0d", e),
            warn_smi, (ew && wsel == 2));
      check(reset_req == er, req, $sformatf("reset_req edge %0d", e), reset_req, er);
      check(reboot_cause == cause_exp, req, $sformatf("reboot_cause edge %0d", e),
            reboot_cause, cause_exp);
      if (kick_at > 0 && e == kick_at - 1) kick = 1'b1;
      if (e == kick_at) kick = 1'b0;
    end
    wd_enable = 1'b0;
    step();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wd_enable = 1'b0; kick = 1'b0; fast_tick = 1'b1;
    warn_sel = 2'd0; reboot_en = 1'b1; free_run = 1'b0;
    stage1_preload = 20'hFFFFF; stage2_preload = 20'hFFFFF; cause_clr = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();

    // R1: reset state and idleness without enable
    check(reboot_cause == 1'b0, "R1", "cause after reset", reboot_cause, 0);
    for (int i = 0; i < 50; i++) begin
      check_quiet("R1", "strobes while never enabled");
      kick = (i == 10);
      step();
    end
    kick = 1'b0;

    // R2 R3 R4 R10: sweep preloads, routing codes and reboot enable
    for (int p1 = 1; p1 <= 3; p1++)
      for (int p2 = 1; p2 <= 2; p2++)
        for (int ws = 0; ws <= 3; ws++)
          run_case(p1, p2, 1'b1, ws, ((p1 + ws) % 2) == 0, 1'b0, 0, "R2 R3 R4 R10");

    // R2: zero preload is a one-edge stage
    run_case(0, 1, 1'b1, 0, 1'b1, 1'b0, 0, "R2");
    run_case(2, 0, 1'b1, 2, 1'b1, 1'b0, 0, "R2");

    // R5: free-running restart, with and without reboot
    run_case(2, 1, 1'b1, 0, 1'b1, 1'b1, 0, "R5");
    run_case(1, 2, 1'b1, 2, 1'b0, 1'b1, 0, "R5");

    // R6 R8: kick positions around both expiries and after a halt
    run_case(2, 1, 1'b1, 0, 1'b1, 1'b0, 10, "R6");
    run_case(2, 1, 1'b1, 0, 1'b1, 1'b0, 63, "R6");
    run_case(2, 1, 1'b1, 0, 1'b1, 1'b0, 64, "R8");
    run_case(2, 1, 1'b1, 0, 1'b1, 1'b0, 65, "R6");
    run_case(2, 1, 1'b1, 2, 1'b1, 1'b0, 96, "R8");
    run_case(2, 1, 1'b1, 0, 1'b1, 1'b0, 101, "R6");

    // R2: coarse prescale
    run_case(1, 1, 1'b0, 2, 1'b1, 1'b0, 0, "R2");

    // R9: cause survives idle cycles, then clears only on cause_clr
    for (int i = 0; i < 20; i++) step();
    check(reboot_cause == 1'b1, "R9", "cause held while idle", reboot_cause, 1);
    cause_clr = 1'b1;
    step();
    cause_clr = 1'b0;
    check(reboot_cause == 1'b0, "R9", "cause after cause_clr", reboot_cause, 0);

    // R7: dropping enable stops the count and kicks are ignored
    fast_tick = 1'b1; warn_sel = 2'd0; reboot_en = 1'b1; free_run = 1'b0;
    stage1_preload = 20'd2; stage2_preload = 20'd1;
    wd_enable = 1'b1;
    for (int i = 0; i < 20; i++) step();
    wd_enable = 1'b0;
    for (int i = 0; i < 150; i++) begin
      step();
      check_quiet("R7", "strobes after disable");
      kick = (i == 30);
    end
    kick = 1'b0;
    check(reboot_cause == 1'b0, "R7", "cause after disable", reboot_cause, 0);
    // R7: the next rise starts a fresh stage 1
    run_case(1, 1, 1'b1, 0, 1'b1, 1'b0, 0, "R7");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule